// File: doc/BRIEF.md
# Open-Drain Output Port Controller

This block holds a four-bit output port register whose bits drive open-drain pins. Each pin is either pulled low or released to high impedance. A latch bit of 0 turns the pin's pull-down on, and a latch bit of 1 releases the pin. Software writes the latch and reads it back through a simple strobe-based register bus. A read always returns the latch contents and never the level on the pin.

When the chip enters a low-power stop state or watch state while the standby pin-state select bit is set, every pull-down is forced off. The latch contents are not changed by this override. Once the standby signals drop, the pins follow the latch again. A pin that serves as an analog input must keep its latch bit at 1 so that its driver stays off. Reset releases every pin.

Top module: `odport_top`

## Requirements
- R1: When `wr_en` is high at a rising clock edge, the latch takes `wr_data` at that edge. Bit i of the latch belongs to pin i.
- R2: When no standby override is active, `pull_low[i]` is 1 exactly when latch bit i is 0 (pin driven low). It is 0 when the latch bit is 1 (pin released).
- R3: `pin_data` is constant 0 on every bit, so each pin resolves to either 0 or Z.
- R4: While `rd_en` is high, `rd_data` shows the latch contents, independent of the pin drive and of the standby inputs. While `rd_en` is low, `rd_data` is 0.
- R5: A rising edge with `rst_n` low sets every latch bit to 1, so all of `pull_low` is 0.
- R6: While (`stop_mode` or `watch_mode`) and `hiz_sel` are all high, all of `pull_low` is 0, whatever the latch holds.
- R7: In stop or watch mode with `hiz_sel` low, the pins keep following the latch as in R2.
- R8: Standby never changes the latch. Writes are still accepted during standby. When standby ends, the drive follows the stored latch again.
- R9: When `wr_en` and `rd_en` are both high in one cycle, `rd_data` returns the old latch value in that cycle. The new value appears from the next cycle.
- R10: When `wr_en` is low at a clock edge, the latch keeps its value.
- R11: `hiz_sel` has no effect on the pins while both mode inputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 4 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_data | output | 4 | Register read data (latch contents) |
| stop_mode | input | 1 | Stop mode active |
| watch_mode | input | 1 | Watch mode active |
| hiz_sel | input | 1 | Standby pin-state select (1 = release pins in standby) |
| pull_low | output | 4 | Per-pin pull-down enable, 1 = drive low |
| pin_data | output | 4 | Tri-state data value per pin, always 0 |

## Verification
The assertions assume that the strobes and mode inputs are stable, known levels at each rising edge. They also assume that the mode inputs may change in any cycle without any handshake to the port. The bench changes every input only on the falling clock edge. It drives each strobe as a clean 0 or 1 and holds the mode signals for whole cycles, including cycles where a write arrives in the middle of standby. This keeps every input inside those assumptions.

// File: rtl/odport_pkg.sv
// Package: odport_pkg
// Shared widths and constants for the open-drain port controller.
// Assumes: all pins of a port share one latch word.
package odport_pkg;
    localparam int unsigned PORT_W = 4;
    typedef logic [PORT_W-1:0] port_word_t;
    localparam port_word_t RELEASED = '1;  // latch value that turns every driver off
endpackage

// File: rtl/odport_latch.sv
// Module: odport_latch
// Holds the port output latch word and updates it on a write strobe.
// Assumes: synchronous active-low reset; wr_en is a single-cycle or held strobe.
module odport_latch #(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] q
);
    localparam logic [WIDTH-1:0] RESET_VAL = '1;

    // Latch update: reset to released, else capture write data.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= RESET_VAL;
        else if (wr_en)
            q <= wr_data;
    end

    assert_reset_ones_R5: assert property (@(posedge clk)
        !rst_n |=> (q == RESET_VAL));
    assert_write_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (q == $past(wr_data)));
    assert_hold_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(q));
endmodule

// File: rtl/odport_drive.sv
// Module: odport_drive
// Turns latch bits into per-pin pull-down enables and applies the standby override.
// Assumes: mode inputs are synchronous levels; the override never touches the latch.
module odport_drive #(
    parameter int unsigned WIDTH = 4
) (
    input  logic [WIDTH-1:0] latch_q,
    input  logic             stop_mode,
    input  logic             watch_mode,
    input  logic             hiz_sel,
    output logic [WIDTH-1:0] pull_low,
    output logic [WIDTH-1:0] pin_data
);
    logic force_off;

    // Standby override: stop or watch mode with the pin-state select set.
    always_comb force_off = (stop_mode | watch_mode) & hiz_sel;

    // Per-pin drive: a zero latch bit pulls low unless overridden.
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        always_comb begin
            pull_low[i] = ~latch_q[i] & ~force_off;
            pin_data[i] = 1'b0;
        end
    end
endmodule

// File: rtl/odport_top.sv
// Module: odport_top
// Four-bit open-drain output port: register latch, readback and standby override.
// Assumes: synchronous active-low reset; readback is combinational and gated by rd_en.
module odport_top (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [3:0] wr_data,
    input  logic       rd_en,
    output logic [3:0] rd_data,
    input  logic       stop_mode,
    input  logic       watch_mode,
    input  logic       hiz_sel,
    output logic [3:0] pull_low,
    output logic [3:0] pin_data
);
    import odport_pkg::*;

    port_word_t latch_q;

    odport_latch #(.WIDTH(PORT_W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .q       (latch_q)
    );

    odport_drive #(.WIDTH(PORT_W)) u_drive (
        .latch_q    (latch_q),
        .stop_mode  (stop_mode),
        .watch_mode (watch_mode),
        .hiz_sel    (hiz_sel),
        .pull_low   (pull_low),
        .pin_data   (pin_data)
    );

    // Readback: latch contents while strobed, zero otherwise.
    always_comb rd_data = rd_en ? latch_q : '0;

    assert_standby_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((stop_mode || watch_mode) && hiz_sel) |-> (pull_low == '0));
    assert_follow_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !((stop_mode || watch_mode) && hiz_sel) |-> (pull_low == ~latch_q));
    assert_read_old_on_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_en) |-> (rd_data == latch_q));
    assert_pin_data_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (pin_data == '0));
endmodule

// File: tb/odport_top_test.sv
module odport_top_test;
    logic       clk = 1'b0;
    logic       rst_n, wr_en, rd_en, stop_mode, watch_mode, hiz_sel;
    logic [3:0] wr_data, rd_data, pull_low, pin_data;
    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    odport_top uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .stop_mode(stop_mode),
        .watch_mode(watch_mode), .hiz_sel(hiz_sel),
        .pull_low(pull_low), .pin_data(pin_data)
    );

    // Vector fields: {wr, wdata[4], stop, watch, hiz, exp_pull[4], exp_rd[4]}
    localparam int NV = 10;
    localparam logic [15:0] VEC [NV] = '{
        {1'b1, 4'b0000, 1'b0, 1'b0, 1'b0, 4'b1111, 4'b0000}, // R1 R2
        {1'b1, 4'b1010, 1'b0, 1'b0, 1'b0, 4'b0101, 4'b1010}, // R1 R2
        {1'b0, 4'b0000, 1'b1, 1'b0, 1'b1, 4'b0000, 4'b1010}, // R6 R10
        {1'b0, 4'b0000, 1'b0, 1'b1, 1'b1, 4'b0000, 4'b1010}, // R6 R8
        {1'b0, 4'b0000, 1'b1, 1'b0, 1'b0, 4'b0101, 4'b1010}, // R7
        {1'b0, 4'b0000, 1'b0, 1'b0, 1'b1, 4'b0101, 4'b1010}, // R11
        {1'b1, 4'b0011, 1'b1, 1'b0, 1'b1, 4'b0000, 4'b0011}, // R8 write in standby
        {1'b0, 4'b0000, 1'b0, 1'b0, 1'b0, 4'b1100, 4'b0011}, // R8 restore
        {1'b1, 4'b1111, 1'b0, 1'b1, 1'b0, 4'b0000, 4'b1111}, // R7 R1
        {1'b0, 4'b0000, 1'b1, 1'b1, 1'b1, 4'b0000, 4'b1111}  // R6
    };

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; rd_en = 1'b0;
        stop_mode = 1'b0; watch_mode = 1'b0; hiz_sel = 1'b0;
        // Preload the latch with zeros so that reset has a visible effect.
        @(negedge clk); rst_n = 1'b1; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0; rst_n = 1'b0;
        @(posedge clk); #5;
        rd_en = 1'b1; #1;
        check("R5 reset readback", rd_data, 4'b1111);
        check("R5 reset drive", pull_low, 4'b0000);
        @(negedge clk); rst_n = 1'b1;

        // Table walk: apply at negedge, sample 5 ns after the next rising edge.
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            wr_en = VEC[v][15]; wr_data = VEC[v][14:11];
            stop_mode = VEC[v][10]; watch_mode = VEC[v][9]; hiz_sel = VEC[v][8];
            rd_en = 1'b1;
            @(posedge clk); #5;
            check($sformatf("R2/R6/R7/R8/R11 vec%0d pull_low", v), pull_low, VEC[v][7:4]);
            check($sformatf("R1/R4/R10 vec%0d rd_data", v), rd_data, VEC[v][3:0]);
            check("R3 pin_data", pin_data, 4'b0000);
        end

        // R4: readback is gated off without the strobe.
        @(negedge clk); wr_en = 1'b0; stop_mode = 1'b0; watch_mode = 1'b0; hiz_sel = 1'b0;
        rd_en = 1'b0; #1;
        check("R4 rd_en low", rd_data, 4'b0000);

        // R9: same-cycle write and read return the old value, then the new one.
        rd_en = 1'b1; wr_en = 1'b1; wr_data = 4'b0110; #1;
        check("R9 old value", rd_data, 4'b1111);
        @(posedge clk); #5;
        wr_en = 1'b0;
        check("R9 new value", rd_data, 4'b0110);
        check("R2 after R9 write", pull_low, 4'b1001);

        // R5: reset in mid operation restores the released state.
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #5;
        check("R5 mid-run reset", rd_data, 4'b1111);
        check("R5 mid-run drive", pull_low, 4'b0000);
        @(negedge clk); rst_n = 1'b1;
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            finish_run();
        end
    end
endmodule